// File: doc/BRIEF.md
# Active Pixel Array Readout Sequencer

This block produces the digital strobes that read out a photogate pixel array one row at a time. Each row goes through a correlated-double-sampling sequence into per-column sample-and-hold stages. The sequence selects the row, pulses the floating node reset and samples the reset level. It then pulses the photogate low to move charge, samples the signal level, and scans the columns of the row in ascending order. Each column select exposes that column's stored pair of levels. A `pix_valid` strobe marks the cycle in which the downstream converter should take the pair.

An offset-cancel mode adds a re-read to every column. After the normal read, a crowbar strobe shorts the two stored levels. The column is then read a second time, and that read is flagged so the converter can subtract the column's own offset. A rectangular window of interest limits the rows and columns that are visited. The window and the mode are captured when a frame is requested. Every phase length comes from a programmable cycle count.

Top module: `aps_readout_seq`

## Requirements
- R1: After reset, and whenever no frame is in progress, all strobes (`row_sel`, `fd_reset`, `samp_rst`, `pg_xfer`, `samp_sig`, `col_sel`, `crowbar`) and `pix_valid`, `frame_start`, `row_start`, `busy` are low; the photogate is therefore left collecting.
- R2: Within a row, the phases run in this order: select, reset pulse, settle, reset-level sample, transfer pulse, settle, signal-level sample, column scan. `row_sel` stays high from the select phase through the signal sample.
- R3: Select and both settle phases last `t_settle` cycles. The reset pulse lasts `t_reset`, each sample lasts `t_sample`, the transfer lasts `t_xfer` and every column phase lasts `t_col`. A count of 0 acts as 1. `busy` is high for exactly the sum of these lengths over all visited rows and columns.
- R4: Neither sample strobe is ever high in the same cycle as `fd_reset` or `pg_xfer`. A settle cycle separates the end of the reset pulse from the reset sample, and the end of the transfer from the signal sample.
- R5: In the column scan, each column is selected for `t_col` cycles. `pix_valid` is high in the last of those cycles, with `pix_cb` = 0 and `row_addr`/`col_addr` naming the pixel.
- R6: With `offset_cancel` set, every normal read is followed by `t_col` cycles of `crowbar` and then a second read of `t_col` cycles. The second read ends with `pix_valid` high and `pix_cb` = 1 at the same address.
- R7: Only rows from `win_row_first` to `win_row_last`, and only columns from `win_col_first` to `win_col_last`, are visited. Rows and columns both go in ascending order, columns within a row.
- R8: If a window's first bound is greater than its last bound, that axis alone reverts to the full array (0 to 127).
- R9: The window inputs and `offset_cancel` are captured in the cycle a frame is accepted. Changing them during a frame has no effect on that frame.
- R10: `frame_start` is high for one cycle, in the first cycle of the first row. `row_start` is high for one cycle at the start of each row. `frame_req` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_req | input | 1 | Request a frame when idle |
| offset_cancel | input | 1 | Enable crowbar re-read per column |
| win_row_first | input | 7 | First row of window |
| win_row_last | input | 7 | Last row of window |
| win_col_first | input | 7 | First column of window |
| win_col_last | input | 7 | Last column of window |
| t_reset | input | 8 | Reset pulse length in cycles |
| t_sample | input | 8 | Sample strobe length in cycles |
| t_xfer | input | 8 | Transfer pulse length in cycles |
| t_settle | input | 8 | Select and settle length in cycles |
| t_col | input | 8 | Column read / crowbar length in cycles |
| row_sel | output | 1 | Row select strobe |
| fd_reset | output | 1 | Floating node reset pulse |
| samp_rst | output | 1 | Reset-level sample strobe |
| pg_xfer | output | 1 | Photogate transfer pulse (gate driven low) |
| samp_sig | output | 1 | Signal-level sample strobe |
| col_sel | output | 1 | Column select strobe |
| crowbar | output | 1 | Crowbar short strobe |
| row_addr | output | 7 | Current row address |
| col_addr | output | 7 | Current column address |
| pix_valid | output | 1 | Pixel pair ready for conversion |
| pix_cb | output | 1 | Marks the crowbar re-read |
| frame_start | output | 1 | First cycle of a frame |
| row_start | output | 1 | First cycle of a row |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the default 128 by 128 array with 8-bit phase counts. This size reaches both the top row and column address 127 and a reverted window spanning all 128 rows or columns, with frames short enough to run several in full. Zero and non-unit phase counts are mixed across the vectors, so the stretching of individual phases and the zero-as-one rule show up in the measured busy length. Offset-cancel frames and windows ending on the array's last pixel cover the address-wrap corner.

// File: rtl/aps_seq_pkg.sv
package aps_seq_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SEL,
        PH_RST,
        PH_GAP1,
        PH_SHR,
        PH_XFER,
        PH_GAP2,
        PH_SHS,
        PH_COL,
        PH_CB,
        PH_CBRD
    } phase_e;

    typedef struct packed {
        logic row_sel;
        logic fd_reset;
        logic samp_rst;
        logic pg_xfer;
        logic samp_sig;
        logic col_sel;
        logic crowbar;
    } strobe_t;

    // Strobe pattern owned by each phase.
    function automatic strobe_t phase_strobes(phase_e p);
        strobe_t s;
        s          = '0;
        s.row_sel  = (p == PH_SEL) || (p == PH_RST) || (p == PH_GAP1) ||
                     (p == PH_SHR) || (p == PH_XFER) || (p == PH_GAP2) ||
                     (p == PH_SHS);
        s.fd_reset = (p == PH_RST);
        s.samp_rst = (p == PH_SHR);
        s.pg_xfer  = (p == PH_XFER);
        s.samp_sig = (p == PH_SHS);
        s.col_sel  = (p == PH_COL) || (p == PH_CB) || (p == PH_CBRD);
        s.crowbar  = (p == PH_CB);
        return s;
    endfunction

endpackage

// File: rtl/aps_win_axis.sv
module aps_win_axis #(
    parameter int N  = 128,
    parameter int AW = $clog2(N)
) (
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    output logic [AW-1:0] lo_o,
    output logic [AW-1:0] hi_o
);
    logic bad;

    always_comb begin
        bad  = (lo_i > hi_i) || (int'(hi_i) >= N);
        lo_o = bad ? '0 : lo_i;
        hi_o = bad ? AW'(N - 1) : hi_i;
        // R8: a resolved window is never inverted
        a_r8_window_ordered: assert (lo_o <= hi_o);
    end
endmodule

// File: rtl/aps_phase_timer.sv
module aps_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] len_i,
    output logic          done_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    // R3: a running phase shortens by exactly one cycle per clock
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == TW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/aps_readout_seq.sv
module aps_readout_seq
    import aps_seq_pkg::*;
#(
    parameter int ROWS = 128,
    parameter int COLS = 128,
    parameter int TW   = 8,
    localparam int RAW = $clog2(ROWS),
    localparam int CAW = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frame_req,
    input  logic           offset_cancel,
    input  logic [RAW-1:0] win_row_first,
    input  logic [RAW-1:0] win_row_last,
    input  logic [CAW-1:0] win_col_first,
    input  logic [CAW-1:0] win_col_last,
    input  logic [TW-1:0]  t_reset,
    input  logic [TW-1:0]  t_sample,
    input  logic [TW-1:0]  t_xfer,
    input  logic [TW-1:0]  t_settle,
    input  logic [TW-1:0]  t_col,
    output logic           row_sel,
    output logic           fd_reset,
    output logic           samp_rst,
    output logic           pg_xfer,
    output logic           samp_sig,
    output logic           col_sel,
    output logic           crowbar,
    output logic [RAW-1:0] row_addr,
    output logic [CAW-1:0] col_addr,
    output logic           pix_valid,
    output logic           pix_cb,
    output logic           frame_start,
    output logic           row_start,
    output logic           busy
);
    phase_e         ph_q, ph_d;
    logic           adv, tmr_done, accept, scan_step;
    logic [TW-1:0]  len_d;
    logic [RAW-1:0] row_q, r_lo_q, r_hi_q, r_lo_w, r_hi_w;
    logic [CAW-1:0] col_q, c_lo_q, c_hi_q, c_lo_w, c_hi_w;
    logic           cb_q, fs_q, rs_q;
    phase_e         scan_next;
    strobe_t        stb;

    aps_win_axis #(.N(ROWS), .AW(RAW)) u_row_win (
        .lo_i(win_row_first), .hi_i(win_row_last), .lo_o(r_lo_w), .hi_o(r_hi_w));

    aps_win_axis #(.N(COLS), .AW(CAW)) u_col_win (
        .lo_i(win_col_first), .hi_i(win_col_last), .lo_o(c_lo_w), .hi_o(c_hi_w));

    aps_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(adv), .len_i(len_d), .done_o(tmr_done));

    assign accept = (ph_q == PH_IDLE) && frame_req;

    always_comb begin
        if (col_q != c_hi_q)      scan_next = PH_COL;
        else if (row_q != r_hi_q) scan_next = PH_SEL;
        else                      scan_next = PH_IDLE;
    end

    always_comb begin
        ph_d = ph_q;
        adv  = 1'b0;
        if (ph_q == PH_IDLE) begin
            if (frame_req) begin
                ph_d = PH_SEL;
                adv  = 1'b1;
            end
        end else if (tmr_done) begin
            adv = 1'b1;
            case (ph_q)
                PH_SEL:  ph_d = PH_RST;
                PH_RST:  ph_d = PH_GAP1;
                PH_GAP1: ph_d = PH_SHR;
                PH_SHR:  ph_d = PH_XFER;
                PH_XFER: ph_d = PH_GAP2;
                PH_GAP2: ph_d = PH_SHS;
                PH_SHS:  ph_d = PH_COL;
                PH_COL:  ph_d = cb_q ? PH_CB : scan_next;
                PH_CB:   ph_d = PH_CBRD;
                PH_CBRD: ph_d = scan_next;
                default: ph_d = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (ph_d)
            PH_SEL, PH_GAP1, PH_GAP2: len_d = t_settle;
            PH_RST:                   len_d = t_reset;
            PH_SHR, PH_SHS:           len_d = t_sample;
            PH_XFER:                  len_d = t_xfer;
            PH_COL, PH_CB, PH_CBRD:   len_d = t_col;
            default:                  len_d = '0;
        endcase
    end

    assign scan_step = adv && (((ph_q == PH_COL) && !cb_q) || (ph_q == PH_CBRD));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            row_q  <= '0;
            col_q  <= '0;
            r_lo_q <= '0;
            r_hi_q <= '0;
            c_lo_q <= '0;
            c_hi_q <= '0;
            cb_q   <= 1'b0;
            fs_q   <= 1'b0;
            rs_q   <= 1'b0;
        end else begin
            ph_q <= ph_d;
            fs_q <= accept;
            rs_q <= adv && (ph_d == PH_SEL);
            if (accept) begin
                r_lo_q <= r_lo_w;
                r_hi_q <= r_hi_w;
                c_lo_q <= c_lo_w;
                c_hi_q <= c_hi_w;
                cb_q   <= offset_cancel;
                row_q  <= r_lo_w;
                col_q  <= c_lo_w;
            end else if (scan_step) begin
                if (col_q != c_hi_q) begin
                    col_q <= col_q + 1'b1;
                end else if (row_q != r_hi_q) begin
                    row_q <= row_q + 1'b1;
                    col_q <= c_lo_q;
                end
            end
        end
    end

    assign stb         = phase_strobes(ph_q);
    assign row_sel     = stb.row_sel;
    assign fd_reset    = stb.fd_reset;
    assign samp_rst    = stb.samp_rst;
    assign pg_xfer     = stb.pg_xfer;
    assign samp_sig    = stb.samp_sig;
    assign col_sel     = stb.col_sel;
    assign crowbar     = stb.crowbar;
    assign row_addr    = row_q;
    assign col_addr    = col_q;
    assign pix_valid   = ((ph_q == PH_COL) || (ph_q == PH_CBRD)) && tmr_done;
    assign pix_cb      = (ph_q == PH_CBRD);
    assign frame_start = fs_q;
    assign row_start   = rs_q;
    assign busy        = (ph_q != PH_IDLE);

    // R2: transfer begins straight after the reset-level sample
    a_r2_xfer_after_shr: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_xfer) |-> $past(samp_rst));

    // R4: a settle cycle lies between reset pulse and reset sample
    a_r4_gap_before_shr: assert property (@(posedge clk) disable iff (rst)
        $rose(samp_rst) |-> !$past(fd_reset));

    // R4: a settle cycle lies between transfer and signal sample
    a_r4_gap_before_shs: assert property (@(posedge clk) disable iff (rst)
        $rose(samp_sig) |-> !$past(pg_xfer));

    // R7: every delivered pixel lies inside the captured window
    a_r7_pix_in_window: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (row_addr >= r_lo_q && row_addr <= r_hi_q &&
                       col_addr >= c_lo_q && col_addr <= c_hi_q));

    // R6: the crowbar only follows a completed normal read
    a_r6_cb_after_read: assert property (@(posedge clk) disable iff (rst)
        $rose(crowbar) |-> $past(pix_valid && !pix_cb));

    // R10: a frame opens with a row start
    a_r10_frame_is_row: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (row_start && busy));

    // R1: no strobe while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(row_sel || fd_reset || samp_rst || pg_xfer || samp_sig ||
                    col_sel || crowbar || pix_valid));
endmodule

// File: tb/aps_readout_seq_tb.sv
module aps_readout_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_req = 1'b0;
    logic       offset_cancel = 1'b0;
    logic [6:0] win_row_first = '0, win_row_last = '0;
    logic [6:0] win_col_first = '0, win_col_last = '0;
    logic [7:0] t_reset = 8'd1, t_sample = 8'd1, t_xfer = 8'd1, t_settle = 8'd1, t_col = 8'd1;
    logic       row_sel, fd_reset, samp_rst, pg_xfer, samp_sig, col_sel, crowbar;
    logic [6:0] row_addr, col_addr;
    logic       pix_valid, pix_cb, frame_start, row_start, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    aps_readout_seq u_dut (
        .clk(clk), .rst(rst), .frame_req(frame_req), .offset_cancel(offset_cancel),
        .win_row_first(win_row_first), .win_row_last(win_row_last),
        .win_col_first(win_col_first), .win_col_last(win_col_last),
        .t_reset(t_reset), .t_sample(t_sample), .t_xfer(t_xfer),
        .t_settle(t_settle), .t_col(t_col),
        .row_sel(row_sel), .fd_reset(fd_reset), .samp_rst(samp_rst),
        .pg_xfer(pg_xfer), .samp_sig(samp_sig), .col_sel(col_sel), .crowbar(crowbar),
        .row_addr(row_addr), .col_addr(col_addr), .pix_valid(pix_valid),
        .pix_cb(pix_cb), .frame_start(frame_start), .row_start(row_start), .busy(busy));

    // Fields: row first, row last, col first, col last, offset mode,
    // t_reset, t_sample, t_xfer, t_settle, t_col,
    // expected pixel strobes, expected busy cycles, expected rows
    localparam int NV = 5;
    localparam int VT [NV][13] = '{
        '{  2,   3,   5,   7, 0, 2, 1, 3, 1, 2,   6,   32,   2},
        '{  2,   3,   5,   7, 1, 2, 1, 3, 1, 2,  12,   56,   2},
        '{ 10,   4,   0,   0, 0, 0, 1, 1, 1, 0, 128, 1024, 128},
        '{127, 127, 127, 127, 1, 1, 1, 1, 1, 3,   2,   16,   1},
        '{  0,   1,  20,   3, 0, 1, 1, 1, 1, 1, 256,  270,   2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int strobe_bits();
        return {row_sel, fd_reset, samp_rst, pg_xfer, samp_sig, col_sel, crowbar,
                pix_valid, frame_start, row_start, busy};
    endfunction

    task automatic run_vec(input int i);
        int er_lo, er_hi, ec_lo, ec_hi, er, ec, ef;
        int busy_n = 0, pix_n = 0, rs_n = 0, fs_n = 0;
        int addr_err = 0, ord_err = 0, lastcode = 0, code;
        bit seen = 0;
        // R8: inverted bounds revert that axis to the full array
        er_lo = (VT[i][0] > VT[i][1]) ? 0   : VT[i][0];
        er_hi = (VT[i][0] > VT[i][1]) ? 127 : VT[i][1];
        ec_lo = (VT[i][2] > VT[i][3]) ? 0   : VT[i][2];
        ec_hi = (VT[i][2] > VT[i][3]) ? 127 : VT[i][3];
        er = er_lo; ec = ec_lo; ef = 0;
        win_row_first = 7'(VT[i][0]); win_row_last = 7'(VT[i][1]);
        win_col_first = 7'(VT[i][2]); win_col_last = 7'(VT[i][3]);
        offset_cancel = VT[i][4][0];
        t_reset = 8'(VT[i][5]); t_sample = 8'(VT[i][6]); t_xfer = 8'(VT[i][7]);
        t_settle = 8'(VT[i][8]); t_col = 8'(VT[i][9]);
        for (int k = 0; k < 20000; k++) begin
            if (k > 0) begin
                if (seen && !busy) break;
                if (busy) begin
                    seen = 1;
                    busy_n++;
                    if (frame_start) begin
                        fs_n++;
                        if (busy_n != 1) ord_err++;
                    end
                    if (row_start) begin
                        rs_n++;
                        lastcode = 0;
                    end
                    code = fd_reset ? 1 : samp_rst ? 2 : pg_xfer ? 3 : samp_sig ? 4 :
                           (col_sel || crowbar) ? 5 : lastcode;
                    if (code < lastcode) ord_err++;
                    lastcode = code;
                    if (code >= 1 && code <= 4 && !row_sel) ord_err++;
                    if ((samp_rst || samp_sig) && (fd_reset || pg_xfer)) ord_err++;
                    if (pix_valid) begin
                        pix_n++;
                        if (int'(row_addr) != er || int'(col_addr) != ec || int'(pix_cb) != ef)
                            addr_err++;
                        if (VT[i][4] != 0 && ef == 0) ef = 1;
                        else begin
                            ef = 0;
                            if (ec == ec_hi) begin ec = ec_lo; er++; end
                            else ec++;
                        end
                    end
                end
            end
            frame_req = (k < 2);
            if (k == 2) begin
                // R9: scramble window and mode after the frame is accepted
                win_row_first = 7'd0; win_row_last = 7'd127;
                win_col_first = 7'd0; win_col_last = 7'd127;
                offset_cancel = ~offset_cancel;
            end
            @(negedge clk);
        end
        check(pix_n == VT[i][10], $sformatf("R5/R6 pixel count v%0d", i), pix_n, VT[i][10]);
        check(busy_n == VT[i][11], $sformatf("R3 busy length v%0d", i), busy_n, VT[i][11]);
        check(addr_err == 0, $sformatf("R7 R8 R9 address order v%0d", i), addr_err, 0);
        check(ord_err == 0, $sformatf("R2 R4 strobe order v%0d", i), ord_err, 0);
        check(fs_n == 1, $sformatf("R10 frame_start count v%0d", i), fs_n, 1);
        check(rs_n == VT[i][12], $sformatf("R10 row_start count v%0d", i), rs_n, VT[i][12]);
        @(negedge clk);
        check(strobe_bits() == 0, $sformatf("R1 idle after frame v%0d", i), strobe_bits(), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check(strobe_bits() == 0, "R1 reset state", strobe_bits(), 0);
        rst = 1'b0;
        @(negedge clk);
        check(strobe_bits() == 0, "R1 idle after reset", strobe_bits(), 0);
        for (int i = 0; i < NV; i++) run_vec(i);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule